// File: doc/BRIEF.md
# Multichannel ADC Conversion Sequencer

This block drives one shared analog-to-digital converter across a host-selected group of input channels. Each selected channel is converted in turn through a simple start/done handshake, and the result is stored in that channel's data register. Two adjacent channels can also be converted together as one differential input, and that result is kept in two's complement.

A trigger begins a sweep. This can be an external pulse or an internal software strobe. In one-shot mode the sweep runs once and the sequencer then waits for the next trigger. In continuous mode it keeps repeating the sweep with no further triggers. Continuous mode is the reset default.

The host learns that results are ready through two outputs: a ready flag and an active-low ready pin. Reading a result clears the flag. Writing the channel selection, writing any threshold register, or changing the mode ends the sweep in progress at once.

Top module: `adcseq_top`

## Requirements
- R1: After reset, every data register reads 0, `readyFlag` is 0, `readyN` is 1 and `convStart` is 0.
- R2: In one-shot mode (mode bit 0), a trigger converts each selected channel exactly once, in ascending channel order. After that the sequencer issues no further starts until the next trigger.
- R3: The mode bit resets to 1 (continuous). In this mode one trigger makes the selected group repeat without end.
- R4: Bit i of `seSel` selects channel i as single-ended. Bit p of `diffSel` selects channel 2p (+) against channel 2p+1 (−) as a differential input. That input is converted in slot 2p with `convDiff`=1, and its result goes to register 2p. While a pair is enabled, the `seSel` bits of both of its channels are ignored.
- R5: Each data register is 16 bits wide and bits 15..12 always read 0. A single-ended result is the raw 12-bit code. A differential result is the raw code with bit 11 inverted, which gives two's complement around mid-scale code 0x800.
- R6: A `selWrite` or `thrWrite` pulse with no trigger in the same cycle stops the sweep in progress. No further start is issued, there is no completion, and a `convDone` still outstanding is ignored, so the register of the channel in flight keeps its old value.
- R7: A mode write whose value differs from the current mode stops the sweep like R6. A mode write with the same value has no effect on the sweep in progress.
- R8: A trigger during a sweep abandons it and starts a new sweep from the lowest selected channel. A trigger wins over any stop event in the same cycle.
- R9: At the end of a one-shot sweep, `readyFlag` goes to 1 and `readyN` goes low, and both stay that way until a read.
- R10: A `rdStrobe` pulse clears `readyFlag` and releases the held `readyN` level. The flag falls only after a read.
- R11: At the end of each continuous sweep, `readyFlag` is set and `readyN` goes low for exactly PULSE_LEN (default 4) clocks.
- R12: Each conversion gets a `convStart` pulse one clock long. `convChan` and `convDiff` stay stable until its `convDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| seSel | input | 16 | Single-ended channel selection |
| diffSel | input | 2 | Differential pair selection |
| selWrite | input | 1 | Channel-selection register written |
| thrWrite | input | 1 | Threshold register written |
| modeWrEn | input | 1 | Mode bit write strobe |
| modeWrData | input | 1 | Mode value written: 1 continuous, 0 one-shot |
| trigExt | input | 1 | External trigger pulse |
| trigInt | input | 1 | Internal trigger pulse |
| convDone | input | 1 | Converter finished the current conversion |
| convResult | input | 12 | Raw converter code, valid with convDone |
| convStart | output | 1 | Start one conversion |
| convChan | output | 4 | Channel to convert |
| convDiff | output | 1 | Conversion is differential |
| rdStrobe | input | 1 | Host read of a result |
| resultFlat | output | 256 | Sixteen 16-bit data registers, channel i at bits 16i+15..16i |
| readyFlag | output | 1 | Results-ready flag |
| readyN | output | 1 | Active-low results-ready pin |

## Verification
A wrong scan pointer shows up at the converter port within one conversion, as a `convChan` out of order or repeated. It then appears in the data registers as soon as that sweep completes. A stuck control state shows up either as missing completions or as starts that continue after a stop or after a one-shot sweep; the bench counts starts tens of clocks after each such event. Errors in the differential and mode handling are exposed as bad register contents by table vectors that mix pairs with overlapping single-ended bits. The ready-pulse width is measured clock by clock.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef struct packed {
    logic ptrClear;
    logic issue;
    logic capture;
  } seqStrobes_t;
endpackage

// File: rtl/adcseq_dpath.sv
module adcseq_dpath
  import adcseq_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int NUM_PAIRS = 2,
  parameter int RES_W     = 12,
  parameter int REG_W     = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH-1:0]       seSel,
  input  logic [NUM_PAIRS-1:0]    diffSel,
  input  seqStrobes_t             strobes,
  input  logic [RES_W-1:0]        convResult,
  output logic                    hasNext,
  output logic [$clog2(NUM_CH)-1:0] convChan,
  output logic                    convDiff,
  output logic [NUM_CH*REG_W-1:0] resultFlat
);
  localparam int CH_W  = $clog2(NUM_CH);
  localparam int PTR_W = CH_W + 1;

  logic [NUM_CH-1:0] chanMask;
  logic [NUM_CH-1:0] diffSlot;
  logic [PTR_W-1:0]  ptr;
  logic [CH_W-1:0]   cur;
  logic              curDiff;
  logic [CH_W-1:0]   nextIdx;
  logic [RES_W-1:0]  captured;
  logic [RES_W-1:0]  resReg [NUM_CH];

  // effective selection per channel: pairs override their single-ended bits
  for (genvar g = 0; g < NUM_CH; g++) begin : g_mask
    if (g < 2 * NUM_PAIRS && (g % 2) == 0) begin : g_lo
      assign chanMask[g] = seSel[g] | diffSel[g/2];
      assign diffSlot[g] = diffSel[g/2];
    end else if (g < 2 * NUM_PAIRS) begin : g_hi
      assign chanMask[g] = seSel[g] & ~diffSel[g/2];
      assign diffSlot[g] = 1'b0;
    end else begin : g_se
      assign chanMask[g] = seSel[g];
      assign diffSlot[g] = 1'b0;
    end
  end

  // lowest selected channel at or above the scan pointer
  always_comb begin
    hasNext = 1'b0;
    nextIdx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (chanMask[i] && (PTR_W'(i) >= ptr)) begin
        hasNext = 1'b1;
        nextIdx = CH_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      cur     <= '0;
      curDiff <= 1'b0;
    end else begin
      if (strobes.ptrClear) ptr <= '0;
      else if (strobes.capture) ptr <= {1'b0, cur} + PTR_W'(1);
      if (strobes.issue) begin
        cur     <= nextIdx;
        curDiff <= diffSlot[nextIdx];
      end
    end
  end

  assign captured = curDiff ? {~convResult[RES_W-1], convResult[RES_W-2:0]} : convResult;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_res
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) resReg[g] <= '0;
      else if (strobes.capture && cur == CH_W'(g)) resReg[g] <= captured;
    end
    assign resultFlat[g*REG_W +: REG_W] = {{(REG_W-RES_W){1'b0}}, resReg[g]};
  end

  assign convChan = cur;
  assign convDiff = curDiff;
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        trigger,
  input  logic        selWrite,
  input  logic        thrWrite,
  input  logic        modeWrEn,
  input  logic        modeWrData,
  input  logic        hasNext,
  input  logic        convDone,
  input  logic        rdStrobe,
  output seqStrobes_t strobes,
  output logic        convStart,
  output logic        readyFlag,
  output logic        readyN
);
  localparam int PC_W = $clog2(PULSE_LEN + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_PICK, ST_WAIT} seqState_t;

  seqState_t        state, stateNext;
  logic             modeAuto;
  logic             flagQ, pinHoldQ, startQ, complete;
  logic [PC_W-1:0]  pulseCnt;
  logic             cfgAbort;

  assign cfgAbort = selWrite | thrWrite | (modeWrEn && (modeWrData != modeAuto));

  always_comb begin
    strobes   = '0;
    stateNext = state;
    complete  = 1'b0;
    if (trigger) begin
      stateNext        = ST_PICK;
      strobes.ptrClear = 1'b1;
    end else if (cfgAbort) begin
      stateNext = ST_IDLE;
    end else begin
      case (state)
        ST_PICK: begin
          if (hasNext) begin
            strobes.issue = 1'b1;
            stateNext     = ST_WAIT;
          end else begin
            complete = 1'b1;
            if (modeAuto) strobes.ptrClear = 1'b1;
            else stateNext = ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (convDone) begin
            strobes.capture = 1'b1;
            stateNext       = ST_PICK;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      modeAuto <= 1'b1;
      flagQ    <= 1'b0;
      pinHoldQ <= 1'b0;
      startQ   <= 1'b0;
      pulseCnt <= '0;
    end else begin
      state  <= stateNext;
      startQ <= strobes.issue;
      if (modeWrEn) modeAuto <= modeWrData;
      if (complete) flagQ <= 1'b1;
      else if (rdStrobe) flagQ <= 1'b0;
      if (complete && !modeAuto) pinHoldQ <= 1'b1;
      else if (rdStrobe) pinHoldQ <= 1'b0;
      if (complete && modeAuto) pulseCnt <= PC_W'(PULSE_LEN);
      else if (pulseCnt != '0) pulseCnt <= pulseCnt - PC_W'(1);
    end
  end

  assign convStart = startQ;
  assign readyFlag = flagQ;
  assign readyN    = !(pinHoldQ || (pulseCnt != '0));
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int NUM_PAIRS = 2,
  parameter int RES_W     = 12,
  parameter int REG_W     = 16,
  parameter int PULSE_LEN = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_CH-1:0]           seSel,
  input  logic [NUM_PAIRS-1:0]        diffSel,
  input  logic                        selWrite,
  input  logic                        thrWrite,
  input  logic                        modeWrEn,
  input  logic                        modeWrData,
  input  logic                        trigExt,
  input  logic                        trigInt,
  input  logic                        convDone,
  input  logic [RES_W-1:0]            convResult,
  output logic                        convStart,
  output logic [$clog2(NUM_CH)-1:0]   convChan,
  output logic                        convDiff,
  input  logic                        rdStrobe,
  output logic [NUM_CH*REG_W-1:0]     resultFlat,
  output logic                        readyFlag,
  output logic                        readyN
);
  seqStrobes_t strobes;
  logic        hasNext;
  logic        trigger;

  assign trigger = trigExt | trigInt;

  adcseq_ctrl #(.PULSE_LEN(PULSE_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .trigger(trigger), .selWrite(selWrite),
    .thrWrite(thrWrite), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .hasNext(hasNext), .convDone(convDone), .rdStrobe(rdStrobe),
    .strobes(strobes), .convStart(convStart), .readyFlag(readyFlag),
    .readyN(readyN)
  );

  adcseq_dpath #(.NUM_CH(NUM_CH), .NUM_PAIRS(NUM_PAIRS), .RES_W(RES_W), .REG_W(REG_W)) u_dpath (
    .clk(clk), .rstN(rstN), .seSel(seSel), .diffSel(diffSel),
    .strobes(strobes), .convResult(convResult), .hasNext(hasNext),
    .convChan(convChan), .convDiff(convDiff), .resultFlat(resultFlat)
  );
endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk (
  input logic clk,
  input logic rstN,
  input logic selWrite,
  input logic thrWrite,
  input logic trigExt,
  input logic trigInt,
  input logic convStart,
  input logic rdStrobe,
  input logic readyFlag,
  input logic readyN
);
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rstN) convStart |=> !convStart); // R12
  AST_SEL_ABORT: assert property (@(posedge clk) disable iff (!rstN) (selWrite && !trigExt && !trigInt) |=> !convStart); // R6
  AST_THR_ABORT: assert property (@(posedge clk) disable iff (!rstN) (thrWrite && !trigExt && !trigInt) |=> !convStart); // R6
  AST_FLAG_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rstN) $fell(readyFlag) |-> $past(rdStrobe)); // R10
  AST_PIN_ON_DONE: assert property (@(posedge clk) disable iff (!rstN) $rose(readyFlag) |-> !readyN); // R9
endmodule

bind adcseq_top adcseq_chk u_chk (
  .clk(clk), .rstN(rstN), .selWrite(selWrite), .thrWrite(thrWrite),
  .trigExt(trigExt), .trigInt(trigInt), .convStart(convStart),
  .rdStrobe(rdStrobe), .readyFlag(readyFlag), .readyN(readyN)
);

// File: tb/adcseq_top_tb.sv
module adcseq_top_tb;
  localparam int PULSE_LEN = 4;
  localparam int LAT = 3;
  localparam logic [29:0] VEC [6] = '{
    {16'h0001, 2'b00, 12'h010},
    {16'h8421, 2'b00, 12'h0A0},
    {16'h00F0, 2'b00, 12'h333},
    {16'h0000, 2'b01, 12'h7F0},
    {16'h000F, 2'b11, 12'h456},
    {16'hFFFF, 2'b10, 12'h901}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, selWrite, thrWrite, modeWrEn, modeWrData, trigExt, trigInt;
  logic convDone, rdStrobe, convStart, convDiff, readyFlag, readyN;
  logic [15:0] seSel;
  logic [1:0] diffSel;
  logic [11:0] convResult;
  logic [3:0] convChan;
  logic [255:0] resultFlat;

  adcseq_top u_dut (.*);

  int errors = 0, checks = 0, startCount = 0;
  int logChan [512];
  bit logDiff [512];
  bit dblStart = 0, chanDrift = 0;
  logic [11:0] seed = '0;
  logic [15:0] expReg [16];
  int expCh [16];
  bit expDf [16];
  int expN;

  function automatic logic [11:0] rawOf(input int ch);
    return 12'(ch * 32'h111) + seed;
  endfunction

  // converter model: answers LAT clocks after each start
  initial begin : conv_model
    int cnt;
    bit pending, prevStart, df;
    logic [3:0] ch;
    pending = 0; cnt = 0; prevStart = 0; df = 0; ch = '0;
    convDone = 0; convResult = '0;
    forever begin
      @(negedge clk);
      convDone = 0;
      if (pending) begin
        if (cnt == 0) begin
          convDone = 1; convResult = rawOf(int'(ch)); pending = 0;
          if (convChan != ch || convDiff != df) chanDrift = 1;
        end else cnt--;
      end
      if (convStart) begin
        if (prevStart) dblStart = 1;
        pending = 1; cnt = LAT; ch = convChan; df = convDiff;
        if (startCount < 512) begin logChan[startCount] = int'(convChan); logDiff[startCount] = convDiff; end
        startCount++;
      end
      prevStart = convStart;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic cycles(input int n); repeat (n) @(negedge clk); endtask
  task automatic doTrig(input bit useInt);
    if (useInt) trigInt = 1; else trigExt = 1;
    @(negedge clk); trigInt = 0; trigExt = 0;
  endtask
  task automatic writeSel(input logic [15:0] se, input logic [1:0] df);
    seSel = se; diffSel = df; selWrite = 1; @(negedge clk); selWrite = 0;
  endtask
  task automatic writeMode(input bit m);
    modeWrEn = 1; modeWrData = m; @(negedge clk); modeWrEn = 0;
  endtask
  task automatic doRead; rdStrobe = 1; @(negedge clk); rdStrobe = 0; endtask
  task automatic waitReady(output bit ok);
    ok = 0;
    for (int k = 0; k < 2000; k++) begin
      if (!readyN) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask
  task automatic waitStarts(input int target);
    for (int k = 0; k < 2000; k++) begin
      if (startCount >= target) break;
      @(negedge clk);
    end
  endtask

  // expected group order and register contents from R4/R5
  task automatic expectGroup(input logic [15:0] se, input logic [1:0] df);
    expN = 0;
    for (int i = 0; i < 16; i++) begin
      bit act, d;
      logic [11:0] raw;
      d = (i < 4 && i % 2 == 0) ? df[i/2] : 1'b0;
      if (i < 4) act = (i % 2 == 0) ? (se[i] | df[i/2]) : (se[i] & ~df[i/2]);
      else act = se[i];
      if (act) begin
        expCh[expN] = i; expDf[expN] = d; expN++;
        raw = rawOf(i);
        expReg[i] = {4'h0, d ? (raw ^ 12'h800) : raw};
      end
    end
  endtask
  task automatic checkRegs(input string req);
    for (int i = 0; i < 16; i++)
      chk(resultFlat[i*16 +: 16] == expReg[i], req, 64'(resultFlat[i*16 +: 16]), 64'(expReg[i]));
  endtask
  task automatic checkLog(input int base, input string req);
    for (int k = 0; k < expN; k++)
      chk(logChan[base+k] == expCh[k] && logDiff[base+k] == expDf[k], req,
          64'(logChan[base+k]), 64'(expCh[k]));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog all requirements actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int base, lowLen, n;
    bit ok;
    rstN = 0; seSel = '0; diffSel = '0; selWrite = 0; thrWrite = 0;
    modeWrEn = 0; modeWrData = 0; trigExt = 0; trigInt = 0; rdStrobe = 0;
    for (int i = 0; i < 16; i++) expReg[i] = '0;
    cycles(3); rstN = 1; cycles(1);

    // R1 reset state
    chk(readyN == 1, "R1 readyN", 64'(readyN), 1);
    chk(readyFlag == 0, "R1 readyFlag", 64'(readyFlag), 0);
    chk(resultFlat == '0, "R1 registers", 64'(resultFlat[63:0]), 0);
    chk(convStart == 0, "R1 convStart", 64'(convStart), 0);

    // R3 default continuous mode, R11 pulse width
    seed = 12'h123;
    writeSel(16'h0F00, 2'b00);
    base = startCount;
    doTrig(0);
    waitReady(ok);
    chk(ok, "R11 continuous completion", 64'(ok), 1);
    lowLen = 0;
    while (!readyN && lowLen < 50) begin lowLen++; @(negedge clk); end
    chk(lowLen == PULSE_LEN, "R11 pulse width", 64'(lowLen), PULSE_LEN);
    chk(readyFlag == 1, "R11 flag set", 64'(readyFlag), 1);
    waitStarts(base + 12);
    chk(startCount - base >= 12, "R3 repeats without trigger", 64'(startCount - base), 12);
    expectGroup(16'h0F00, 2'b00);
    checkLog(base, "R3 order");
    checkLog(base + 4, "R3 second sweep");
    checkRegs("R5 single-ended data");
    doRead;
    chk(readyFlag == 0, "R10 read clears flag", 64'(readyFlag), 0);
    waitReady(ok);
    chk(ok && readyFlag == 1, "R11 flag set again", 64'(readyFlag), 1);

    // R7 differing mode write stops the sweep
    writeMode(0);
    cycles(2);
    n = startCount;
    cycles(40);
    chk(startCount == n, "R7 mode change stops", 64'(startCount - n), 0);
    doRead;
    chk(readyFlag == 0 && readyN == 1, "R10 released", 64'({readyFlag, readyN}), 1);

    // table of one-shot vectors: R2 R4 R5 R9 R10
    for (int v = 0; v < 6; v++) begin
      seed = VEC[v][11:0];
      writeSel(VEC[v][29:14], VEC[v][13:12]);
      base = startCount;
      doTrig(v % 2 == 1);
      waitReady(ok);
      chk(ok && readyFlag, "R9 one-shot completion", 64'(readyFlag), 1);
      cycles(3);
      chk(readyN == 0, "R9 pin held low", 64'(readyN), 0);
      expectGroup(VEC[v][29:14], VEC[v][13:12]);
      chk(startCount - base == expN, "R2 once per channel", 64'(startCount - base), 64'(expN));
      checkLog(base, "R2 R4 order and pair slot");
      checkRegs("R5 R4 stored data");
      doRead;
      chk(readyFlag == 0 && readyN == 1, "R10 read releases", 64'({readyFlag, readyN}), 1);
      cycles(20);
      chk(startCount - base == expN, "R2 idle after sweep", 64'(startCount - base), 64'(expN));
    end

    // R7 same-value mode write does not stop the sweep
    seed = 12'h2A0;
    writeSel(16'h00F0, 2'b00);
    base = startCount;
    doTrig(0);
    waitStarts(base + 1);
    writeMode(0);
    waitReady(ok);
    chk(ok, "R7 same mode keeps sweep", 64'(ok), 1);
    expectGroup(16'h00F0, 2'b00);
    checkRegs("R7 data after same-mode write");
    doRead;

    // R6 selection write stops the sweep, outstanding done ignored
    seed = 12'h3C3;
    writeSel(16'h00F0, 2'b00);
    base = startCount;
    doTrig(0);
    waitStarts(base + 1);
    writeSel(16'h00F0, 2'b00);
    cycles(30);
    chk(startCount == base + 1, "R6 select write stops", 64'(startCount - base), 1);
    chk(readyFlag == 0 && readyN == 1, "R6 no completion", 64'({readyFlag, readyN}), 1);
    checkRegs("R6 registers unchanged");

    // R6 threshold write stops the sweep
    seed = 12'h5A5;
    base = startCount;
    doTrig(1);
    waitStarts(base + 1);
    thrWrite = 1; @(negedge clk); thrWrite = 0;
    cycles(30);
    chk(startCount == base + 1, "R6 threshold write stops", 64'(startCount - base), 1);
    checkRegs("R6 registers unchanged after threshold write");

    // R8 retrigger restarts at the lowest selected channel
    seed = 12'h055;
    base = startCount;
    doTrig(0);
    waitStarts(base + 2);
    doTrig(0);
    waitReady(ok);
    expectGroup(16'h00F0, 2'b00);
    chk(ok && startCount - base == 2 + expN, "R8 restart count", 64'(startCount - base), 64'(2 + expN));
    checkLog(base + 2, "R8 restart order");
    checkRegs("R8 data");
    doRead;

    chk(!dblStart, "R12 single-cycle start", 64'(dblStart), 0);
    chk(!chanDrift, "R12 channel held until done", 64'(chanDrift), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule